// File: doc/BRIEF.md
# Nibble Accumulator Execute Unit

This block carries out the data-handling instructions of a small 4-bit accumulator machine. It takes one 8-bit instruction byte in each cycle in which `instr_valid` is high. It keeps a 4-bit accumulator, a carry flag and a 6-bit data pointer. The pointer is built from a 2-bit high part (H) and a 4-bit low part (L). A 64-nibble data memory lives inside the block and is addressed by `{H, L}`, or directly by a second instruction byte. Fetch, branching and the program counter sit outside. The surrounding sequencer reads `skip_o` and knows that the next instruction it presents will be discarded without effect.

Control is a three-state machine:
- OPCODE takes a first byte.
- OPERAND takes the direct-address byte of a memory increment or decrement.
- DISCARD swallows the second byte of a two-byte instruction that is being skipped.

The transitions are as follows:
- OPCODE to OPERAND on an executed two-byte opcode.
- OPCODE to DISCARD on a skipped two-byte opcode.
- OPERAND to OPCODE, and DISCARD to OPCODE, on the next valid byte.
- All other cases stay where they are.

A kind register records whether the last executed instruction was an accumulator immediate load, a pointer immediate load, or anything else. This register implements load stacking.

Top module: `nibble_exec_unit`

## Requirements
- R1: Reset clears the following: accumulator, carry, H, L, skip flag, all 64 memory nibbles, and the kind register. The machine returns to OPCODE.
- R2: Load stacking applies to two opcodes. `0001 iiii` loads iiii into A, and `110x iiii` loads the pointer. If either one directly follows an executed instruction of the same form, it is ignored, and the chain of ignored loads persists.
- R3: `0000 iiii` adds iiii to A, raises skip when the sum carries out of bit 3, and leaves carry unchanged.
- R4: The arithmetic and logic opcodes use the nibble at HL.
  - `0111 1101` adds that nibble to A and skips on carry out, with carry unchanged.
  - `0111 1100` adds that nibble plus carry to A and stores the carry out in carry.
  - `0111 1110` XORs that nibble into A.
  - `0111 1111` inverts A.
- R5: `0111 1000` clears carry and `0111 1001` sets carry.
- R6: `0010 10hh` loads hh into H. `110x iiii` loads H with {0, x} and L with iiii.
- R7: `0101 00rr` loads A from the nibble at HL. `0101 01rr` swaps A with that nibble (rr=11 of the second form is a store, see R8). The rr field selects the pointer update: rr=00 leaves L unchanged; rr=01 decrements L after the access and skips when L passes 0 to F; rr=10 increments L after the access and skips when L passes F to 0. `0101 0011` is a no-op.
- R8: `0101 0111` stores A at HL. `0100 iiii` stores iiii at HL, then increments L, with no skip.
- R9: `0111 1011` swaps A and L.
- R10: `0101 1001` increments L and skips when the result is 0. `0101 1000` decrements L and skips when the result is F.
- R11: `0011 1101` increments the nibble at the address given by the low 6 bits of the following byte, and skips when the result is 0. `0011 1100` decrements that nibble and skips when the result is F.
- R12: `0110 10bb` clears bit bb of the nibble at HL. `0110 11bb` sets that bit.
- R13: `skip_o` rises after a skipping instruction and falls when the next opcode byte is consumed. That skipped instruction changes no register or memory, including the second byte of a two-byte instruction.
- R14: Opcodes outside the group change nothing. A cycle with `instr_valid` low also changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction byte present this cycle |
| instr_byte | input | 8 | Opcode or direct-address byte |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag |
| h_o | output | 2 | Pointer high part |
| l_o | output | 4 | Pointer low part |
| skip_o | output | 1 | Next instruction will be skipped |

## Verification
Every result is registered, so the accumulator, carry, H, L and skip flag all settle one clock edge after the byte that causes them. A memory write becomes visible only to a following read instruction, and a two-byte instruction's effect appears one edge after its second byte. The bench drives each byte on a falling edge, deasserts `instr_valid` at the next falling edge, and compares all outputs there, half a cycle after the capturing rising edge. Memory contents are checked by issuing a load through the accumulator and reading it one edge later.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int NIB_W     = 4;
    localparam int H_W       = 2;
    localparam int L_W       = 4;
    localparam int ADDR_W    = H_W + L_W;
    localparam int MEM_DEPTH = 1 << ADDR_W;
    localparam int OPC_W     = 8;
    localparam int IMM5_W    = 5;
    localparam int BSEL_W    = $clog2(NIB_W);

    typedef enum logic [4:0] {
        OP_NOP, OP_LDA_IMM, OP_ADD_IMM, OP_LDH_IMM, OP_LDHL_IMM,
        OP_LDA_MEM, OP_SWAP_MEM, OP_STORE, OP_STORE_IMM, OP_SWAP_L,
        OP_INVERT, OP_ADD_MEM, OP_ADDC_MEM, OP_XOR_MEM, OP_CLR_C,
        OP_SET_C, OP_INC_L, OP_DEC_L, OP_INC_DIR, OP_DEC_DIR,
        OP_CLR_BIT, OP_SET_BIT
    } op_e;

    typedef enum logic [1:0] {
        PTR_KEEP = 2'b00,
        PTR_DEC  = 2'b01,
        PTR_INC  = 2'b10,
        PTR_RSVD = 2'b11
    } ptr_e;

    typedef enum logic [1:0] {
        K_OTHER, K_LOAD_A, K_LOAD_HL
    } kind_e;

    typedef enum logic [1:0] {
        ST_OPCODE, ST_OPERAND, ST_DISCARD
    } fsm_e;

    typedef struct packed {
        op_e                op;
        logic [IMM5_W-1:0]  imm5;
        ptr_e               ptr;
        logic [BSEL_W-1:0]  bsel;
    } dec_t;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_pkg::*;
(
    input  logic [OPC_W-1:0] byte_i,
    output dec_t             dec_o
);
    always_comb begin
        dec_o.imm5 = byte_i[IMM5_W-1:0];
        dec_o.ptr  = ptr_e'(byte_i[1:0]);
        dec_o.bsel = byte_i[BSEL_W-1:0];
        casez (byte_i)
            8'b0000_????: dec_o.op = OP_ADD_IMM;
            8'b0001_????: dec_o.op = OP_LDA_IMM;
            8'b0010_10??: dec_o.op = OP_LDH_IMM;
            8'b0011_1100: dec_o.op = OP_DEC_DIR;
            8'b0011_1101: dec_o.op = OP_INC_DIR;
            8'b0100_????: dec_o.op = OP_STORE_IMM;
            8'b0101_0011: dec_o.op = OP_NOP;
            8'b0101_0111: dec_o.op = OP_STORE;
            8'b0101_00??: dec_o.op = OP_LDA_MEM;
            8'b0101_01??: dec_o.op = OP_SWAP_MEM;
            8'b0101_1000: dec_o.op = OP_DEC_L;
            8'b0101_1001: dec_o.op = OP_INC_L;
            8'b0110_10??: dec_o.op = OP_CLR_BIT;
            8'b0110_11??: dec_o.op = OP_SET_BIT;
            8'b0111_1000: dec_o.op = OP_CLR_C;
            8'b0111_1001: dec_o.op = OP_SET_C;
            8'b0111_1011: dec_o.op = OP_SWAP_L;
            8'b0111_1100: dec_o.op = OP_ADDC_MEM;
            8'b0111_1101: dec_o.op = OP_ADD_MEM;
            8'b0111_1110: dec_o.op = OP_XOR_MEM;
            8'b0111_1111: dec_o.op = OP_INVERT;
            8'b110?_????: dec_o.op = OP_LDHL_IMM;
            default:      dec_o.op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
(
    input  dec_t             dec_i,
    input  logic [NIB_W-1:0] acc_i,
    input  logic             carry_i,
    input  logic [H_W-1:0]   h_i,
    input  logic [L_W-1:0]   l_i,
    input  logic [NIB_W-1:0] mem_i,
    output logic [NIB_W-1:0] acc_o,
    output logic             carry_o,
    output logic [H_W-1:0]   h_o,
    output logic [L_W-1:0]   l_o,
    output logic             mem_we_o,
    output logic [NIB_W-1:0] mem_wdata_o,
    output logic             skip_o
);
    localparam logic [L_W-1:0]   L_ONE   = L_W'(1);
    localparam logic [NIB_W-1:0] BIT_ONE = NIB_W'(1);

    logic [NIB_W:0] sum;

    always_comb begin
        acc_o       = acc_i;
        carry_o     = carry_i;
        h_o         = h_i;
        l_o         = l_i;
        mem_we_o    = 1'b0;
        mem_wdata_o = acc_i;
        skip_o      = 1'b0;
        sum         = '0;
        case (dec_i.op)
            OP_LDA_IMM: acc_o = dec_i.imm5[NIB_W-1:0];
            OP_ADD_IMM: begin
                sum    = {1'b0, acc_i} + {1'b0, dec_i.imm5[NIB_W-1:0]};
                acc_o  = sum[NIB_W-1:0];
                skip_o = sum[NIB_W];
            end
            OP_LDH_IMM: h_o = dec_i.imm5[H_W-1:0];
            OP_LDHL_IMM: begin
                h_o = H_W'(dec_i.imm5[IMM5_W-1]);
                l_o = dec_i.imm5[L_W-1:0];
            end
            OP_LDA_MEM, OP_SWAP_MEM: begin
                acc_o = mem_i;
                if (dec_i.op == OP_SWAP_MEM) begin
                    mem_we_o    = 1'b1;
                    mem_wdata_o = acc_i;
                end
                case (dec_i.ptr)
                    PTR_DEC: begin
                        l_o    = l_i - L_ONE;
                        skip_o = (l_i == '0);
                    end
                    PTR_INC: begin
                        l_o    = l_i + L_ONE;
                        skip_o = (l_i == '1);
                    end
                    default: ;
                endcase
            end
            OP_STORE: mem_we_o = 1'b1;
            OP_STORE_IMM: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = dec_i.imm5[NIB_W-1:0];
                l_o         = l_i + L_ONE;
            end
            OP_SWAP_L: begin
                acc_o = l_i;
                l_o   = acc_i;
            end
            OP_INVERT: acc_o = ~acc_i;
            OP_ADD_MEM: begin
                sum    = {1'b0, acc_i} + {1'b0, mem_i};
                acc_o  = sum[NIB_W-1:0];
                skip_o = sum[NIB_W];
            end
            OP_ADDC_MEM: begin
                sum     = {1'b0, acc_i} + {1'b0, mem_i} + {{NIB_W{1'b0}}, carry_i};
                acc_o   = sum[NIB_W-1:0];
                carry_o = sum[NIB_W];
            end
            OP_XOR_MEM: acc_o = acc_i ^ mem_i;
            OP_CLR_C:   carry_o = 1'b0;
            OP_SET_C:   carry_o = 1'b1;
            OP_INC_L: begin
                l_o    = l_i + L_ONE;
                skip_o = (l_i == '1);
            end
            OP_DEC_L: begin
                l_o    = l_i - L_ONE;
                skip_o = (l_i == '0);
            end
            OP_CLR_BIT: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = mem_i & ~(BIT_ONE << dec_i.bsel);
            end
            OP_SET_BIT: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = mem_i | (BIT_ONE << dec_i.bsel);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nib_mem.sv
module nib_mem #(
    parameter int AW = 6,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (we_i && (waddr_i == AW'(g))) begin
                cells[g] <= wdata_i;
            end
        end
    end

    assign rdata_a_o = cells[raddr_a_i];
    assign rdata_b_o = cells[raddr_b_i];
endmodule

// File: rtl/nibble_exec_unit.sv
module nibble_exec_unit
    import nib_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [OPC_W-1:0] instr_byte,
    output logic [NIB_W-1:0] acc_o,
    output logic             carry_o,
    output logic [H_W-1:0]   h_o,
    output logic [L_W-1:0]   l_o,
    output logic             skip_o
);
    localparam logic [NIB_W-1:0] NIB_ONE = NIB_W'(1);

    fsm_e              state_q, state_d;
    kind_e             kind_q;
    logic [NIB_W-1:0]  acc_q;
    logic              carry_q;
    logic [H_W-1:0]    h_q;
    logic [L_W-1:0]    l_q;
    logic              skip_q;
    logic              dir_inc_q;

    dec_t              dec;
    logic [NIB_W-1:0]  alu_acc, alu_wdata, mem_hl, mem_dir, dir_res;
    logic              alu_carry, alu_we, alu_skip;
    logic [H_W-1:0]    alu_h;
    logic [L_W-1:0]    alu_l;

    logic              take_op, two_byte, stacked, exec_op, drop_op, exec_dir, dir_skip;
    logic              mem_we;
    logic [ADDR_W-1:0] hl_addr, dir_addr, mem_waddr;
    logic [NIB_W-1:0]  mem_wdata;

    nib_decode u_dec (
        .byte_i (instr_byte),
        .dec_o  (dec)
    );

    nib_alu u_alu (
        .dec_i       (dec),
        .acc_i       (acc_q),
        .carry_i     (carry_q),
        .h_i         (h_q),
        .l_i         (l_q),
        .mem_i       (mem_hl),
        .acc_o       (alu_acc),
        .carry_o     (alu_carry),
        .h_o         (alu_h),
        .l_o         (alu_l),
        .mem_we_o    (alu_we),
        .mem_wdata_o (alu_wdata),
        .skip_o      (alu_skip)
    );

    nib_mem #(.AW(ADDR_W), .DW(NIB_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (mem_we),
        .waddr_i   (mem_waddr),
        .wdata_i   (mem_wdata),
        .raddr_a_i (hl_addr),
        .rdata_a_o (mem_hl),
        .raddr_b_i (dir_addr),
        .rdata_b_o (mem_dir)
    );

    always_comb begin
        hl_addr  = {h_q, l_q};
        dir_addr = instr_byte[ADDR_W-1:0];
        take_op  = instr_valid && (state_q == ST_OPCODE);
        two_byte = (dec.op == OP_INC_DIR) || (dec.op == OP_DEC_DIR);
        stacked  = ((dec.op == OP_LDA_IMM)  && (kind_q == K_LOAD_A)) ||
                   ((dec.op == OP_LDHL_IMM) && (kind_q == K_LOAD_HL));
        exec_op  = take_op && !skip_q && !stacked;
        drop_op  = take_op && skip_q;
        exec_dir = instr_valid && (state_q == ST_OPERAND);
        dir_res  = dir_inc_q ? (mem_dir + NIB_ONE) : (mem_dir - NIB_ONE);
        dir_skip = dir_inc_q ? (dir_res == '0) : (dir_res == '1);
        mem_we   = (exec_op && alu_we) || exec_dir;
        mem_waddr = exec_dir ? dir_addr : hl_addr;
        mem_wdata = exec_dir ? dir_res : alu_wdata;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: begin
                if (take_op && two_byte) begin
                    state_d = skip_q ? ST_DISCARD : ST_OPERAND;
                end
            end
            ST_OPERAND: if (instr_valid) state_d = ST_OPCODE;
            ST_DISCARD: if (instr_valid) state_d = ST_OPCODE;
            default:    state_d = ST_OPCODE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            carry_q   <= 1'b0;
            h_q       <= '0;
            l_q       <= '0;
            skip_q    <= 1'b0;
            kind_q    <= K_OTHER;
            dir_inc_q <= 1'b0;
        end else if (exec_op) begin
            acc_q   <= alu_acc;
            carry_q <= alu_carry;
            h_q     <= alu_h;
            l_q     <= alu_l;
            skip_q  <= alu_skip;
            if (dec.op == OP_LDA_IMM) begin
                kind_q <= K_LOAD_A;
            end else if (dec.op == OP_LDHL_IMM) begin
                kind_q <= K_LOAD_HL;
            end else begin
                kind_q <= K_OTHER;
            end
            if (two_byte) begin
                dir_inc_q <= (dec.op == OP_INC_DIR);
            end
        end else if (drop_op) begin
            skip_q <= 1'b0;
            kind_q <= K_OTHER;
        end else if (exec_dir) begin
            skip_q <= dir_skip;
        end
    end

    assign acc_o   = acc_q;
    assign carry_o = carry_q;
    assign h_o     = h_q;
    assign l_o     = l_q;
    assign skip_o  = skip_q;
endmodule

// File: rtl/nib_exec_checker.sv
module nib_exec_checker
    import nib_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [OPC_W-1:0] instr_byte,
    input logic [NIB_W-1:0] acc_o,
    input logic             carry_o,
    input logic [H_W-1:0]   h_o,
    input logic [L_W-1:0]   l_o,
    input logic             skip_o,
    input fsm_e             state_q,
    input kind_e            kind_q
);
    logic opc_cycle, run_cycle;
    assign opc_cycle = instr_valid && (state_q == ST_OPCODE);
    assign run_cycle = opc_cycle && !skip_o;

    assert_skip_one_instr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        opc_cycle && skip_o |=> !skip_o);

    assert_skipped_no_change_R13: assert property (@(posedge clk) disable iff (!rst_n)
        opc_cycle && skip_o |=> $stable(acc_o) && $stable(carry_o) && $stable(h_o) && $stable(l_o));

    assert_clear_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_cycle && instr_byte == 8'h78 |=> !carry_o);

    assert_set_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_cycle && instr_byte == 8'h79 |=> carry_o);

    assert_add_imm_keeps_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        opc_cycle && instr_byte[7:4] == 4'h0 |=> $stable(carry_o));

    assert_idle_no_change_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(acc_o) && $stable(carry_o) && $stable(h_o) && $stable(l_o) && $stable(skip_o));

    assert_load_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cycle && instr_byte[7:4] == 4'h1 && kind_q != K_LOAD_A |=> acc_o == $past(instr_byte[3:0]));

    assert_stacked_load_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cycle && instr_byte[7:4] == 4'h1 && kind_q == K_LOAD_A |=> $stable(acc_o));

    assert_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_cycle && instr_byte == 8'h7F |=> acc_o == ~$past(acc_o));

    assert_swap_l_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_cycle && instr_byte == 8'h7B |=> acc_o == $past(l_o) && l_o == $past(acc_o));
endmodule

bind nibble_exec_unit nib_exec_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_byte  (instr_byte),
    .acc_o       (acc_o),
    .carry_o     (carry_o),
    .h_o         (h_o),
    .l_o         (l_o),
    .skip_o      (skip_o),
    .state_q     (state_q),
    .kind_q      (kind_q)
);

// File: tb/tb_nibble_exec_unit.sv
`timescale 1ns/1ps
module tb_nibble_exec_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic [7:0] instr_byte = 8'h00;
    logic [3:0] acc_o;
    logic       carry_o;
    logic [1:0] h_o;
    logic [3:0] l_o;
    logic       skip_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    nibble_exec_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_byte  (instr_byte),
        .acc_o       (acc_o),
        .carry_o     (carry_o),
        .h_o         (h_o),
        .l_o         (l_o),
        .skip_o      (skip_o)
    );

    // {byte, A, C, H, L, skip, requirement number}
    localparam int NV = 56;
    localparam logic [27:0] VEC [NV] = '{
        {8'h17, 4'h7, 1'b0, 2'd0, 4'h0, 1'b0, 8'd2},   // R2 load A
        {8'h13, 4'h7, 1'b0, 2'd0, 4'h0, 1'b0, 8'd2},   // R2 stacked, ignored
        {8'h0A, 4'h1, 1'b0, 2'd0, 4'h0, 1'b1, 8'd3},   // R3 carry out -> skip
        {8'h1F, 4'h1, 1'b0, 2'd0, 4'h0, 1'b0, 8'd13},  // R13 skipped
        {8'h0E, 4'hF, 1'b0, 2'd0, 4'h0, 1'b0, 8'd3},   // R3 no carry
        {8'hC5, 4'hF, 1'b0, 2'd0, 4'h5, 1'b0, 8'd6},   // R6 load HL
        {8'hD2, 4'hF, 1'b0, 2'd0, 4'h5, 1'b0, 8'd2},   // R2 stacked HL load
        {8'h57, 4'hF, 1'b0, 2'd0, 4'h5, 1'b0, 8'd8},   // R8 mem5=F
        {8'h59, 4'hF, 1'b0, 2'd0, 4'h6, 1'b0, 8'd10},  // R10 inc L
        {8'h43, 4'hF, 1'b0, 2'd0, 4'h7, 1'b0, 8'd8},   // R8 mem6=3, L+1
        {8'h58, 4'hF, 1'b0, 2'd0, 4'h6, 1'b0, 8'd10},  // R10 dec L
        {8'h7D, 4'h2, 1'b0, 2'd0, 4'h6, 1'b1, 8'd4},   // R4 add mem, skip
        {8'h7F, 4'h2, 1'b0, 2'd0, 4'h6, 1'b0, 8'd13},  // R13 skipped invert
        {8'h79, 4'h2, 1'b1, 2'd0, 4'h6, 1'b0, 8'd5},   // R5 set carry
        {8'h7C, 4'h6, 1'b0, 2'd0, 4'h6, 1'b0, 8'd4},   // R4 add with carry
        {8'h7E, 4'h5, 1'b0, 2'd0, 4'h6, 1'b0, 8'd4},   // R4 xor
        {8'h7B, 4'h6, 1'b0, 2'd0, 4'h5, 1'b0, 8'd9},   // R9 swap A/L
        {8'h51, 4'hF, 1'b0, 2'd0, 4'h4, 1'b0, 8'd7},   // R7 load, L post-dec
        {8'h7F, 4'h0, 1'b0, 2'd0, 4'h4, 1'b0, 8'd4},   // R4 invert
        {8'h6F, 4'h0, 1'b0, 2'd0, 4'h4, 1'b0, 8'd12},  // R12 set bit3
        {8'h6C, 4'h0, 1'b0, 2'd0, 4'h4, 1'b0, 8'd12},  // R12 set bit0
        {8'h6B, 4'h0, 1'b0, 2'd0, 4'h4, 1'b0, 8'd12},  // R12 clear bit3
        {8'h50, 4'h1, 1'b0, 2'd0, 4'h4, 1'b0, 8'd12},  // R12 mem4 == 1
        {8'h1C, 4'hC, 1'b0, 2'd0, 4'h4, 1'b0, 8'd2},   // R2 load after other
        {8'h54, 4'h1, 1'b0, 2'd0, 4'h4, 1'b0, 8'd7},   // R7 swap with mem
        {8'h50, 4'hC, 1'b0, 2'd0, 4'h4, 1'b0, 8'd7},   // R7 mem4 == C
        {8'h7A, 4'hC, 1'b0, 2'd0, 4'h4, 1'b0, 8'd14},  // R14 unused opcode
        {8'h3D, 4'hC, 1'b0, 2'd0, 4'h4, 1'b0, 8'd11},  // R11 first byte
        {8'h04, 4'hC, 1'b0, 2'd0, 4'h4, 1'b0, 8'd11},  // R11 mem4 -> D
        {8'h50, 4'hD, 1'b0, 2'd0, 4'h4, 1'b0, 8'd11},  // R11 read back
        {8'h79, 4'hD, 1'b1, 2'd0, 4'h4, 1'b0, 8'd5},   // R5
        {8'h78, 4'hD, 1'b0, 2'd0, 4'h4, 1'b0, 8'd5},   // R5 clear carry
        {8'h29, 4'hD, 1'b0, 2'd1, 4'h4, 1'b0, 8'd6},   // R6 load H
        {8'h50, 4'h0, 1'b0, 2'd1, 4'h4, 1'b0, 8'd6},   // R6 reads addr 0x14
        {8'h3C, 4'h0, 1'b0, 2'd1, 4'h4, 1'b0, 8'd11},  // R11 first byte
        {8'h14, 4'h0, 1'b0, 2'd1, 4'h4, 1'b1, 8'd11},  // R11 0 -> F, skip
        {8'h1F, 4'h0, 1'b0, 2'd1, 4'h4, 1'b0, 8'd13},  // R13 skipped
        {8'h50, 4'hF, 1'b0, 2'd1, 4'h4, 1'b0, 8'd11},  // R11 read back F
        {8'hD0, 4'hF, 1'b0, 2'd1, 4'h0, 1'b0, 8'd6},   // R6 H = {0,1}
        {8'h52, 4'h0, 1'b0, 2'd1, 4'h1, 1'b0, 8'd7},   // R7 post-inc
        {8'hCF, 4'h0, 1'b0, 2'd0, 4'hF, 1'b0, 8'd6},   // R6
        {8'h52, 4'h0, 1'b0, 2'd0, 4'h0, 1'b1, 8'd7},   // R7 L F->0 skip
        {8'h3D, 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 8'd13},  // R13 skipped 2-byte
        {8'h04, 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 8'd13},  // R13 operand dropped
        {8'hC4, 4'h0, 1'b0, 2'd0, 4'h4, 1'b0, 8'd6},   // R6
        {8'h50, 4'hD, 1'b0, 2'd0, 4'h4, 1'b0, 8'd13},  // R13 mem4 still D
        {8'h51, 4'hD, 1'b0, 2'd0, 4'h3, 1'b0, 8'd7},   // R7 post-dec no skip
        {8'hC0, 4'hD, 1'b0, 2'd0, 4'h0, 1'b0, 8'd6},   // R6
        {8'h51, 4'h0, 1'b0, 2'd0, 4'hF, 1'b1, 8'd7},   // R7 L 0->F skip
        {8'h59, 4'h0, 1'b0, 2'd0, 4'hF, 1'b0, 8'd13},  // R13 skipped inc L
        {8'h59, 4'h0, 1'b0, 2'd0, 4'h0, 1'b1, 8'd10},  // R10 L -> 0 skip
        {8'h0F, 4'h0, 1'b0, 2'd0, 4'h0, 1'b0, 8'd13},  // R13 skipped add
        {8'h58, 4'h0, 1'b0, 2'd0, 4'hF, 1'b1, 8'd10},  // R10 L -> F skip
        {8'h58, 4'h0, 1'b0, 2'd0, 4'hF, 1'b0, 8'd13},  // R13 skipped dec L
        {8'h58, 4'h0, 1'b0, 2'd0, 4'hE, 1'b0, 8'd10},  // R10 plain dec
        {8'hE7, 4'h0, 1'b0, 2'd0, 4'hE, 1'b0, 8'd14}   // R14 unused opcode
    };

    task automatic check(input string tag, input logic [3:0] ea, input logic ec,
                         input logic [1:0] eh, input logic [3:0] el, input logic es);
        n_checks++;
        if (acc_o !== ea || carry_o !== ec || h_o !== eh || l_o !== el || skip_o !== es) begin
            n_fail++;
            $display("FAIL %s: got A=%h C=%b H=%h L=%h S=%b, expected A=%h C=%b H=%h L=%h S=%b",
                     tag, acc_o, carry_o, h_o, l_o, skip_o, ea, ec, eh, el, es);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_byte  = b;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][27:20]);
            check($sformatf("R%0d vector %0d byte %h", VEC[i][7:0], i, VEC[i][27:20]),
                  VEC[i][19:16], VEC[i][15], VEC[i][14:13], VEC[i][12:9], VEC[i][8]);
        end

        // R14: byte present but valid low has no effect
        @(negedge clk);
        instr_byte = 8'h7F;
        repeat (4) @(negedge clk);
        check("R14 valid low", 4'h0, 1'b0, 2'd0, 4'hE, 1'b0);

        // R1: reset mid-run clears registers and memory
        send(8'h79);
        check("R5 set before reset", 4'h0, 1'b1, 2'd0, 4'hE, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset after run", 4'h0, 1'b0, 2'd0, 4'h0, 1'b0);
        send(8'hC4);
        check("R1 pointer load after reset", 4'h0, 1'b0, 2'd0, 4'h4, 1'b0);
        send(8'h50);
        check("R1 memory cleared", 4'h0, 1'b0, 2'd0, 4'h4, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule